// File: doc/BRIEF.md
# Pipelined Multichannel Converter Interface Controller

This block is a serial-bus master for an external multiplexed successive-approximation converter. The converter takes a 14-bit configuration word in every frame, and the sample read back in any frame belongs to the configuration sent two frames before it. The controller hides that two-deep pipeline. A client gives a channel number with a one-cycle start strobe. The block then sends as many configuration frames as the pipeline needs, reads the data frame, and returns the result right-aligned with a one-cycle valid strobe.

After reset the controller runs a fixed wake-up sequence on its own. It sends one configuration frame and then two discarded conversion reads on channel 0. Between any two frames the select line stays inactive for a programmable number of clock cycles. Frame timing is set by a clock divider. Resolution (14 or 16 bits), channel count (4 or 8) and the reference code are parameters.

Top module: `adc_pipe_ctrl`

## Requirements
- R1: A frame holds `cs_n` low for exactly 16 SCLK periods. Each period is SCLK_HALF cycles low, then SCLK_HALF cycles high. SCLK is low whenever `cs_n` is high.
- R2: Every frame shifts out MSB first the 16-bit word {cfg[13:0], 2'b00}. The fields of cfg are: bit 13 = 1 (apply), bits 12:10 = 3'b111 (single-ended to ground), bits 9:7 = channel, bit 6 = 1 (full bandwidth), bits 5:3 = REF_CODE, bits 2:1 = 2'b00 (no scan), bit 0 = 1 (no readback).
- R3: A request for the same channel as the last completed one takes exactly 2 frames: one configuration frame, then the data frame.
- R4: A request for a different channel takes exactly 3 frames: two configuration frames, then the data frame.
- R5: After reset the block runs exactly 5 frames, all for channel 0, and then goes idle. These are one setup frame and two conversion reads of two frames each. During this sequence `busy` is high and no result is issued.
- R6: `res_data` equals the 16-bit word received on `miso` during the data frame, first bit the MSB, shifted right by 16-RES_BITS.
- R7: Between the end of one frame and the start of the next, `cs_n` stays high for at least GAP_CYC cycles.
- R8: `busy` is high from the cycle after an accepted start until the result cycle. It is low in the cycle `res_valid` is high. `res_valid` lasts one cycle. No frame runs while `busy` is low.
- R9: A start strobe while `busy` is high is ignored. It does not change the channel served, the frame count or the number of results.
- R10: The last-channel record changes only when a data frame completes. An ignored start therefore has no effect on how many frames the next request takes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe |
| chan | input | $clog2(NUM_CH) | Requested channel, sampled with `start` |
| busy | output | 1 | Request or wake-up sequence in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | RES_BITS | Right-aligned conversion result |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to converter |
| cs_n | output | 1 | Frame select, active low |
| miso | input | 1 | Serial data from converter |

## Verification
`busy` is due one clock edge after an accepted start. `res_valid` and `res_data` are due one edge after `cs_n` rises at the end of the data frame. The frame count of a request is known only when that strobe arrives, so the bench keys its result and frame-count checks to the observed strobe. It samples every output at the falling clock edge, midway between the edges where the outputs change. A behavioural converter model in the bench rebuilds every received word from the MOSI bits it samples, so the bench checks each frame when `cs_n` rises. Gap length, SCLK idle level and the busy/valid relation are compared on every clock.

// File: rtl/adc_pipe_pkg.sv
package adc_pipe_pkg;
  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned CFG_BITS   = 14;

  // configuration word: apply, input kind, channel, bandwidth, ref, scan, no-readback
  function automatic logic [CFG_BITS-1:0] build_cfg(input logic [2:0] ch,
                                                     input logic [2:0] refsel);
    return {1'b1, 3'b111, ch, 1'b1, refsel, 2'b00, 1'b1};
  endfunction

  // left-justify the configuration in a frame, two idle bits after it
  function automatic logic [FRAME_BITS-1:0] frame_word(input logic [CFG_BITS-1:0] cfg);
    return {cfg, 2'b00};
  endfunction

  // drop trailing pad bits so the result is right-aligned
  function automatic logic [FRAME_BITS-1:0] right_align(input logic [FRAME_BITS-1:0] w,
                                                         input int unsigned res);
    return w >> (FRAME_BITS - res);
  endfunction

  // frames per request: data frame plus one or two configuration frames
  function automatic logic [2:0] frames_for(input logic same_ch);
    return same_ch ? 3'd2 : 3'd3;
  endfunction

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_XFER = 2'd2
  } seq_state_t;
endpackage

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter #(
  parameter int unsigned SCLK_HALF = 2,
  localparam int unsigned NBITS    = adc_pipe_pkg::FRAME_BITS,
  localparam int unsigned DIV_W    = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1,
  localparam int unsigned BIT_W    = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic [NBITS-1:0] tx_word,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n,
  output logic             active,
  output logic             done,
  output logic [NBITS-1:0] rx_word
);
  logic [DIV_W-1:0] div_cnt;
  logic [BIT_W-1:0] bit_cnt;
  logic             sclk_q;
  logic [NBITS-1:0] tx_sh;
  logic [NBITS-1:0] rx_sh;
  logic             half_end;

  assign half_end = (32'(div_cnt) == SCLK_HALF - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      done    <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      sclk_q  <= 1'b0;
      tx_sh   <= '0;
      rx_sh   <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (kick) begin
          active  <= 1'b1;
          tx_sh   <= tx_word;
          div_cnt <= '0;
          bit_cnt <= '0;
          sclk_q  <= 1'b0;
        end
      end else if (half_end) begin
        div_cnt <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_sh  <= {rx_sh[NBITS-2:0], miso};
        end else begin
          sclk_q <= 1'b0;
          tx_sh  <= {tx_sh[NBITS-2:0], 1'b0};
          if (32'(bit_cnt) == NBITS - 1) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = active & tx_sh[NBITS-1];
  assign cs_n    = ~active;
  assign rx_word = rx_sh;
endmodule

// File: rtl/adc_gap_timer.sv
module adc_gap_timer #(
  parameter int unsigned GAP_CYC = 8,
  localparam int unsigned CNT_W  = $clog2(GAP_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done,
  input  logic frame_active,
  output logic gap_ok
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (frame_done) begin
      cnt <= '0;
    end else if (32'(cnt) != GAP_CYC) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign gap_ok = (32'(cnt) == GAP_CYC) && !frame_active && !frame_done;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_pipe_pkg::*;
#(
  parameter int unsigned RES_BITS = 14,
  parameter int unsigned NUM_CH   = 8,
  parameter logic [2:0]  REF_CODE = 3'd1,
  localparam int unsigned CH_W    = $clog2(NUM_CH),
  localparam int unsigned INIT_FRAMES = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CH_W-1:0]       chan,
  input  logic                  gap_ok,
  input  logic                  frame_done,
  input  logic [FRAME_BITS-1:0] rx_word,
  output logic                  kick,
  output logic [FRAME_BITS-1:0] tx_word,
  output logic                  busy,
  output logic                  res_valid,
  output logic [RES_BITS-1:0]   res_data,
  output logic                  accept,
  output logic                  data_done
);
  seq_state_t      state;
  logic [2:0]      remaining;
  logic            init_q;
  logic [CH_W-1:0] req_ch;
  logic [CH_W-1:0] last_ch;

  assign accept    = (state == ST_IDLE) && start;
  assign kick      = (state == ST_GAP) && gap_ok;
  assign data_done = (state == ST_XFER) && frame_done && (remaining == 3'd1);
  assign busy      = (state != ST_IDLE);
  assign tx_word   = frame_word(build_cfg(3'(req_ch), REF_CODE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_GAP;
      remaining <= 3'(INIT_FRAMES);
      init_q    <= 1'b1;
      req_ch    <= '0;
      last_ch   <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            req_ch    <= chan;
            remaining <= frames_for(chan == last_ch);
            state     <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (kick) state <= ST_XFER;
        end
        ST_XFER: begin
          if (frame_done) begin
            if (remaining == 3'd1) begin
              state   <= ST_IDLE;
              last_ch <= req_ch;
              if (init_q) begin
                init_q <= 1'b0;
              end else begin
                res_valid <= 1'b1;
                res_data  <= RES_BITS'(right_align(rx_word, RES_BITS));
              end
            end else begin
              remaining <= remaining - 1'b1;
              state     <= ST_GAP;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_pipe_ctrl.sv
module adc_pipe_ctrl #(
  parameter int unsigned RES_BITS  = 14,
  parameter int unsigned NUM_CH    = 8,
  parameter int unsigned SCLK_HALF = 2,
  parameter int unsigned GAP_CYC   = 8,
  parameter logic [2:0]  REF_CODE  = 3'd1,
  localparam int unsigned CH_W     = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CH_W-1:0]     chan,
  output logic                busy,
  output logic                res_valid,
  output logic [RES_BITS-1:0] res_data,
  output logic                sclk,
  output logic                mosi,
  output logic                cs_n,
  input  logic                miso
);
  localparam int unsigned FB = adc_pipe_pkg::FRAME_BITS;

  // named internal events, observed by the bound checker
  logic          kick;
  logic          frame_done;
  logic          frame_active;
  logic          gap_ok;
  logic          accept;
  logic          data_done;
  logic [FB-1:0] tx_word;
  logic [FB-1:0] rx_word;

  adc_seq_ctrl #(
    .RES_BITS(RES_BITS),
    .NUM_CH  (NUM_CH),
    .REF_CODE(REF_CODE)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .chan      (chan),
    .gap_ok    (gap_ok),
    .frame_done(frame_done),
    .rx_word   (rx_word),
    .kick      (kick),
    .tx_word   (tx_word),
    .busy      (busy),
    .res_valid (res_valid),
    .res_data  (res_data),
    .accept    (accept),
    .data_done (data_done)
  );

  adc_gap_timer #(
    .GAP_CYC(GAP_CYC)
  ) u_gap (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_done  (frame_done),
    .frame_active(frame_active),
    .gap_ok      (gap_ok)
  );

  adc_frame_shifter #(
    .SCLK_HALF(SCLK_HALF)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick   (kick),
    .tx_word(tx_word),
    .miso   (miso),
    .sclk   (sclk),
    .mosi   (mosi),
    .cs_n   (cs_n),
    .active (frame_active),
    .done   (frame_done),
    .rx_word(rx_word)
  );
endmodule

// File: rtl/adc_pipe_ctrl_chk.sv
module adc_pipe_ctrl_chk #(
  parameter int unsigned GAP_CYC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic res_valid,
  input logic sclk,
  input logic cs_n,
  input logic kick,
  input logic frame_done,
  input logic data_done
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hi_cnt <= '0;
    else if (!cs_n)            hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
  end

  a_r1_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  a_r1_done_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> cs_n);
  a_r7_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (32'(hi_cnt) >= GAP_CYC));
  a_r8_valid_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !busy);
  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
  a_r6_valid_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(data_done));
  a_r7_kick_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> cs_n);
endmodule

bind adc_pipe_ctrl adc_pipe_ctrl_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .res_valid (res_valid),
  .sclk      (sclk),
  .cs_n      (cs_n),
  .kick      (kick),
  .frame_done(frame_done),
  .data_done (data_done)
);

// File: tb/test_adc_pipe_ctrl.sv
module test_adc_pipe_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RES   = 14;
  localparam int NCH   = 8;
  localparam int HALF  = 2;
  localparam int GAP   = 6;
  localparam logic [2:0] REFC = 3'd1;

  logic clk = 0, rst_n = 0, start = 0, miso = 0;
  logic [2:0] chan = '0;
  logic busy, res_valid, sclk, mosi, cs_n;
  logic [RES-1:0] res_data;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_pipe_ctrl #(.RES_BITS(RES), .NUM_CH(NCH), .SCLK_HALF(HALF),
                  .GAP_CYC(GAP), .REF_CODE(REFC)) i_adc_pipe_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .busy(busy),
    .res_valid(res_valid), .res_data(res_data), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .miso(miso));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural converter: sample value of a channel, MSB-first in 16 bits
  function automatic logic [15:0] sample_of(input int ch);
    logic [15:0] v = 16'((ch * 16'h0935 + 16'h0123) & ((1 << RES) - 1));
    return v << (16 - RES);
  endfunction

  function automatic logic [13:0] want_cfg(input int ch);
    return {1'b1, 3'b111, 3'(ch), 1'b1, REFC, 2'b00, 1'b1};
  endfunction

  // model state
  logic [13:0] cfg_hist[$];
  logic [15:0] out_word, in_word;
  int bitpos = 0, rises = 0, hi_cycles = 0, frames = 0, valids = 0;
  int exp_ch = 0, exp_frames = 0, last_model = 0;
  bit in_req = 0, prev_cs = 1, prev_sclk = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      // per-clock comparisons
      check(!(cs_n && sclk), "R1 sclk idle", sclk, 0);
      if (res_valid) check(!busy, "R8 busy low at valid", busy, 0);
      else if (in_req) check(busy, "R8 busy during request", busy, 1);
      if (!in_req && frames >= 5 && !res_valid && !busy)
        check(cs_n, "R8 no frame while idle", cs_n, 1);

      if (prev_cs && !cs_n) begin
        check(hi_cycles >= GAP, "R7 gap", hi_cycles, GAP);
        out_word = (cfg_hist.size() >= 2) ? sample_of(int'(cfg_hist[cfg_hist.size()-2][9:7]))
                                          : 16'h0;
        miso = out_word[15]; bitpos = 0; rises = 0; in_word = '0;
      end
      if (!cs_n && !prev_sclk && sclk) begin
        in_word = {in_word[14:0], mosi}; rises++;
      end
      if (!cs_n && prev_sclk && !sclk && bitpos < 15) begin
        bitpos++; miso = out_word[15 - bitpos];
      end
      if (!prev_cs && cs_n) begin
        check(rises == 16, "R1 sclk periods", rises, 16);
        check(in_word[1:0] == 2'b00, "R2 pad bits", in_word[1:0], 0);
        check(in_word[15:2] == want_cfg(exp_ch), "R2 cfg word", in_word[15:2], want_cfg(exp_ch));
        cfg_hist.push_back(in_word[15:2]);
        frames++;
      end
      hi_cycles = cs_n ? hi_cycles + 1 : 0;

      if (res_valid) begin
        check(in_req, "R9 single result", 0, 1);
        check(frames == exp_frames, "R3/R4 frame count", frames, exp_frames);
        check(32'(res_data) == 32'(sample_of(exp_ch) >> (16 - RES)), "R6 result",
              res_data, sample_of(exp_ch) >> (16 - RES));
        valids++; in_req = 0; last_model = exp_ch;
      end
      prev_cs = cs_n; prev_sclk = sclk;
    end
  end

  task automatic request(input int ch, input bit poke, input int other);
    int t = 0;
    @(negedge clk);
    exp_ch = ch;
    exp_frames = (ch == last_model) ? 2 : 3;
    if (ch == last_model) check(exp_frames == 2, "R3 same channel", exp_frames, 2);
    else check(exp_frames == 3, "R4 new channel", exp_frames, 3);
    frames = 0; start = 1; chan = 3'(ch);
    @(negedge clk);
    start = 0; in_req = 1;
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1; chan = 3'(other);   // R9, R10: must be ignored
      @(negedge clk);
      start = 0;
    end
    while (in_req && t < 5000) begin @(negedge clk); t++; end
    check(!in_req, "R8 result arrived", in_req, 0);
    repeat (3) @(negedge clk);
    check(!busy && cs_n, "R9 stays idle after result", busy, 0);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000 - 100) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    int t = 0;
    repeat (3) @(negedge clk);
    check(cs_n == 1 && sclk == 0 && res_valid == 0, "R1 reset state", cs_n, 1);
    rst_n = 1;
    @(negedge clk);
    check(busy, "R5 busy during wake-up", busy, 1);
    while (busy && t < 5000) begin @(negedge clk); t++; end
    check(frames == 5, "R5 wake-up frames", frames, 5);
    check(valids == 0, "R5 no result in wake-up", valids, 0);
    request(0, 0, 0);  // R3 after wake-up on channel 0
    request(0, 0, 0);
    request(5, 0, 0);  // R4
    request(5, 0, 0);
    request(7, 0, 0);
    request(2, 0, 0);
    request(3, 1, 6);  // R9 ignored start for channel 6
    request(3, 0, 0);  // R10 last channel still 3: two frames
    request(6, 0, 0);
    check(valids == 9, "R9 result count", valids, 9);
    report();
  end
endmodule